// File: doc/BRIEF.md
# Multi-Mode Peripheral Timer

This block is a 16-bit down-counting peripheral timer whose behaviour is chosen by an 8-bit mode register. One counter serves four operating modes: a free-running reload timer, an external event counter, a single-shot pulse generator and a pulse-width modulator. Software sets it up through a small register write port. It chooses one of four prescaled clock enables as the count source and starts or stops the counter with a run bit. It reads back the mode, the status, the reload and compare values and the live count through a registered read port.

The block drives a single output pin, used as a one-shot pulse, a PWM waveform or an underflow toggle. It also holds a sticky underflow flag. The prescaled enables come from outside, and the event input may be asynchronous to the block clock.

Top module: `multimode_timer`

## Requirements
- R1: On synchronous reset every register (mode, run, flag, reload, compare, count) is zero, `tmr_out` is low and `rd_data` reads zero.
- R2: Mode bits 1:0 select the mode (00 reload timer, 01 event counter, 10 one-shot, 11 PWM). Mode bits 7:6 select which bit of `tick_en` paces the counter in the timer, one-shot and PWM modes.
- R3: In timer mode a start (control write at address 1 with bit 0 set while stopped) loads the count from the reload value. Each enabled tick then decrements it. A tick at count zero reloads the count and sets the flag.
- R4: In event mode the count decrements once per rising edge of `evt_in`, detected after a two-flop synchronizer, so the count changes on the third clock edge after the edge is sampled. A held level does not count.
- R5: In one-shot mode a start loads the reload value and raises the output on the same edge. The tick at count zero lowers the output, clears the run bit and sets the flag, so the output stays high for reload+1 ticks.
- R6: In PWM mode a start loads all ones and the count decrements per tick, wrapping from zero to all ones and setting the flag on the wrap. The output follows `count < compare`, one clock later, while running.
- R7: A mode write while running is held pending, and reads of the mode still return the active value. It takes effect on the edge that clears the run bit, whether software or the one-shot clears it.
- R8: Mode bit 2 inverts the output in every mode. Mode bit 3 toggles the output on each reload in timer and event modes. Any applied mode write returns the internal output level to low.
- R9: Writing address 1 with bit 1 set clears the flag. A flag-setting event in the same cycle wins.
- R10: Reads return, one clock after `rd_addr` is presented: address 0 mode, 1 {flag in bit 1, run in bit 0}, 2 reload, 3 compare, 4 count, and zero elsewhere. Writes use address 0 mode, 1 control, 2 reload, 3 compare.
- R11: The count holds while stopped and while the selected source enable stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | CNT_W | Register write data |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | CNT_W | Registered read data |
| tick_en | input | 2**SRC_W | Prescaled clock enables, one per source |
| evt_in | input | 1 | External event input (asynchronous) |
| tmr_out | output | 1 | Pulse / PWM / toggle output |
| uf_flag | output | 1 | Sticky underflow / wrap flag |

## Verification
The reload timer runs from an always-on source, from a half-rate source and from a source held low. A wrong source decode or a count that moves without a tick shows up as a count mismatch. The event counter gets several separated pulses followed by a long high level, which separates edge detection from level sensitivity and fixes the synchronizer latency. The one-shot and PWM runs show the exact edge where the output rises and falls, the PWM run covering a full wrap. Mode writes made during a run, and inversion and toggle settings applied between runs, show when a mode change takes effect.

// File: rtl/mmt_pkg.sv
`timescale 1ns/1ps
package mmt_pkg;
  typedef enum logic [1:0] {
    MD_TIMER   = 2'b00,
    MD_EVENT   = 2'b01,
    MD_ONESHOT = 2'b10,
    MD_PWM     = 2'b11
  } mmt_mode_e;

  // register addresses
  localparam int unsigned RA_MODE   = 0;
  localparam int unsigned RA_CTRL   = 1;
  localparam int unsigned RA_RELOAD = 2;
  localparam int unsigned RA_CMP    = 3;
  localparam int unsigned RA_COUNT  = 4;

  // mode register layout
  localparam int unsigned MODE_W = 8;
  localparam int unsigned MB_INV = 2;
  localparam int unsigned MB_TOG = 3;
endpackage

// File: rtl/mmt_sync.sv
`timescale 1ns/1ps
module mmt_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  // STAGES synchronizer flops followed by one history flop
  logic [STAGES:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[STAGES-1:0], din};
  end

  assign rise = chain_q[STAGES-1] & ~chain_q[STAGES];
endmodule

// File: rtl/mmt_regs.sv
`timescale 1ns/1ps
module mmt_regs
  import mmt_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic              os_done,
  input  logic              uf_pulse,
  output logic [MODE_W-1:0] mode_q,
  output logic              run_q,
  output logic              flag_q,
  output logic [CNT_W-1:0]  reload_q,
  output logic [CNT_W-1:0]  cmp_q,
  output logic              start_pulse,
  output logic              apply_pulse
);
  logic              wr_mode, wr_ctrl, wr_rel, wr_cmp;
  logic              run_clear;
  logic [MODE_W-1:0] pend_q;
  logic              pend_v;

  assign wr_mode = wr_en && (wr_addr == ADDR_W'(RA_MODE));
  assign wr_ctrl = wr_en && (wr_addr == ADDR_W'(RA_CTRL));
  assign wr_rel  = wr_en && (wr_addr == ADDR_W'(RA_RELOAD));
  assign wr_cmp  = wr_en && (wr_addr == ADDR_W'(RA_CMP));

  assign start_pulse = wr_ctrl && wr_data[0] && !run_q;
  assign run_clear   = run_q && ((wr_ctrl && !wr_data[0]) || (!wr_ctrl && os_done));
  assign apply_pulse = (wr_mode && !run_q) || (run_clear && (pend_v || wr_mode));

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q    <= 1'b0;
      flag_q   <= 1'b0;
      reload_q <= '0;
      cmp_q    <= '0;
      mode_q   <= '0;
      pend_q   <= '0;
      pend_v   <= 1'b0;
    end else begin
      if (wr_ctrl)      run_q <= wr_data[0];
      else if (os_done) run_q <= 1'b0;

      if (uf_pulse)                 flag_q <= 1'b1;
      else if (wr_ctrl && wr_data[1]) flag_q <= 1'b0;

      if (wr_rel) reload_q <= wr_data;
      if (wr_cmp) cmp_q    <= wr_data;

      if (run_clear && (pend_v || wr_mode)) begin
        mode_q <= wr_mode ? wr_data[MODE_W-1:0] : pend_q;
        pend_v <= 1'b0;
      end else if (wr_mode && !run_q) begin
        mode_q <= wr_data[MODE_W-1:0];
        pend_v <= 1'b0;
      end else if (wr_mode) begin
        pend_q <= wr_data[MODE_W-1:0];
        pend_v <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/mmt_core.sv
`timescale 1ns/1ps
module mmt_core
  import mmt_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  mmt_mode_e        mode_sel,
  input  logic             tog_en,
  input  logic             start_pulse,
  input  logic             apply_pulse,
  input  logic             run,
  input  logic             step,
  input  logic [CNT_W-1:0] reload,
  input  logic [CNT_W-1:0] cmp,
  output logic [CNT_W-1:0] cnt_q,
  output logic             lvl_q,
  output logic             uf_pulse,
  output logic             os_done
);
  logic at_zero;

  assign at_zero  = (cnt_q == '0);
  assign uf_pulse = step && run && !start_pulse && at_zero;
  assign os_done  = uf_pulse && (mode_sel == MD_ONESHOT);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (start_pulse) begin
      cnt_q <= (mode_sel == MD_PWM) ? '1 : reload;
    end else if (step && run) begin
      if (at_zero && (mode_sel == MD_TIMER || mode_sel == MD_EVENT))
        cnt_q <= reload;
      else if (!(at_zero && mode_sel == MD_ONESHOT))
        cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q <= 1'b0;
    end else if (apply_pulse) begin
      lvl_q <= 1'b0;
    end else begin
      unique case (mode_sel)
        MD_TIMER, MD_EVENT: if (uf_pulse && tog_en) lvl_q <= ~lvl_q;
        MD_ONESHOT: begin
          if (start_pulse)          lvl_q <= 1'b1;
          else if (os_done || !run) lvl_q <= 1'b0;
        end
        MD_PWM: lvl_q <= run && (cnt_q < cmp);
        default: lvl_q <= lvl_q;
      endcase
    end
  end
endmodule

// File: rtl/multimode_timer.sv
`timescale 1ns/1ps
module multimode_timer
  import mmt_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned ADDR_W      = 3,
  parameter int unsigned SRC_W       = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [CNT_W-1:0]    wr_data,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [CNT_W-1:0]    rd_data,
  input  logic [2**SRC_W-1:0] tick_en,
  input  logic                evt_in,
  output logic                tmr_out,
  output logic                uf_flag
);
  localparam int unsigned SRC_LSB = MODE_W - SRC_W;

  logic [MODE_W-1:0] mode_q;
  logic              run_q, flag_q;
  logic [CNT_W-1:0]  reload_q, cmp_q, cnt_q;
  logic              start_pulse, apply_pulse;
  logic              uf_pulse, os_done;
  logic              evt_rise, step, lvl_q;
  mmt_mode_e         mode_sel;
  logic [CNT_W-1:0]  rd_d;

  assign mode_sel = mmt_mode_e'(mode_q[1:0]);

  mmt_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .os_done(os_done), .uf_pulse(uf_pulse), .mode_q(mode_q), .run_q(run_q),
    .flag_q(flag_q), .reload_q(reload_q), .cmp_q(cmp_q),
    .start_pulse(start_pulse), .apply_pulse(apply_pulse)
  );

  mmt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(evt_in), .rise(evt_rise)
  );

  assign step = run_q && ((mode_sel == MD_EVENT) ? evt_rise
                                                 : tick_en[mode_q[MODE_W-1:SRC_LSB]]);

  mmt_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .tog_en(mode_q[MB_TOG]),
    .start_pulse(start_pulse), .apply_pulse(apply_pulse), .run(run_q),
    .step(step), .reload(reload_q), .cmp(cmp_q), .cnt_q(cnt_q),
    .lvl_q(lvl_q), .uf_pulse(uf_pulse), .os_done(os_done)
  );

  always_comb begin
    rd_d = '0;
    case (rd_addr)
      ADDR_W'(RA_MODE):   rd_d = CNT_W'(mode_q);
      ADDR_W'(RA_CTRL):   rd_d = CNT_W'({flag_q, run_q});
      ADDR_W'(RA_RELOAD): rd_d = reload_q;
      ADDR_W'(RA_CMP):    rd_d = cmp_q;
      ADDR_W'(RA_COUNT):  rd_d = cnt_q;
      default:            rd_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_d;
  end

  assign tmr_out = lvl_q ^ mode_q[MB_INV];
  assign uf_flag = flag_q;
endmodule

// File: rtl/mmt_checker.sv
`timescale 1ns/1ps
module mmt_checker #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned ADDR_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [CNT_W-1:0]  rd_data,
  input logic [CNT_W-1:0]  cnt,
  input logic              run,
  input logic [7:0]        mode,
  input logic              uf_pulse,
  input logic              uf_flag,
  input logic              tmr_out
);
  // R10: count read appears one clock after the address
  p_rd_count_r10: assert property (@(posedge clk) disable iff (rst)
    (rd_addr == ADDR_W'(4)) |=> (rd_data == $past(cnt)));

  // R9: a flag-setting event always leaves the flag set
  p_flag_set_r9: assert property (@(posedge clk) disable iff (rst)
    uf_pulse |=> uf_flag);

  // R11: stopped counter without a control write keeps its count
  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (!run && !(wr_en && wr_addr == ADDR_W'(1))) |=> $stable(cnt));

  // R7: active mode cannot change while the counter keeps running
  p_mode_lock_r7: assert property (@(posedge clk) disable iff (rst)
    run |=> (!run || $stable(mode)));

  // R5: a running non-inverted one-shot drives the output high
  p_os_high_r5: assert property (@(posedge clk) disable iff (rst)
    (run && mode[1:0] == 2'b10 && !mode[2]) |-> tmr_out);
endmodule

bind multimode_timer mmt_checker #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .rd_addr(rd_addr),
  .rd_data(rd_data), .cnt(cnt_q), .run(run_q), .mode(mode_q),
  .uf_pulse(uf_pulse), .uf_flag(uf_flag), .tmr_out(tmr_out)
);

// File: tb/multimode_timer_test.sv
`timescale 1ns/1ps
module multimode_timer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  rd_addr = 3'd4;
  logic [15:0] rd_data;
  logic [3:0]  tick_en = 4'b0001;
  logic        evt_in = 1'b0;
  logic        tmr_out, uf_flag;

  int    n_cmp = 0, n_bad = 0;
  string cur_req = "R1";
  int    phase = 0;
  bit    running = 1'b1;

  always #2.5 clk = ~clk;

  multimode_timer uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .tick_en(tick_en), .evt_in(evt_in),
    .tmr_out(tmr_out), .uf_flag(uf_flag)
  );

  // source 0 every clock, 1 every second clock, 2 every fourth, 3 never
  always @(negedge clk) begin
    phase = phase + 1;
    tick_en = {1'b0, (phase % 4) == 0, (phase % 2) == 0, 1'b1};
  end

  // ---------------- behavioural reference model ----------------
  logic [7:0]  m_mode, m_pend;
  logic        m_pv, m_run, m_flag, m_lvl, m_s1, m_s2, m_s3;
  logic [15:0] m_rel, m_cmp, m_cnt, m_rd;

  always @(posedge clk) begin
    logic        wm, wc, tk, st, zh, dn, cl, ap;
    logic [1:0]  kind;
    logic [15:0] ncnt, nrd;
    logic        nlvl;
    if (rst) begin
      m_mode = 0; m_pend = 0; m_pv = 0; m_run = 0; m_flag = 0; m_lvl = 0;
      m_s1 = 0; m_s2 = 0; m_s3 = 0; m_rel = 0; m_cmp = 0; m_cnt = 0; m_rd = 0;
    end else begin
      wm   = wr_en && wr_addr == 0;
      wc   = wr_en && wr_addr == 1;
      kind = m_mode[1:0];
      tk   = m_run && ((kind == 1) ? (m_s2 && !m_s3) : tick_en[m_mode[7:6]]);
      st   = wc && wr_data[0] && !m_run;
      zh   = tk && !st && m_cnt == 0;
      dn   = zh && kind == 2;
      cl   = m_run && ((wc && !wr_data[0]) || (!wc && dn));
      ap   = (wm && !m_run) || (cl && (m_pv || wm));
      ncnt = m_cnt;
      if (st) ncnt = (kind == 3) ? 16'hFFFF : m_rel;
      else if (tk) begin
        if (m_cnt == 0 && kind < 2) ncnt = m_rel;
        else if (!(m_cnt == 0 && kind == 2)) ncnt = m_cnt - 16'd1;
      end
      nlvl = m_lvl;
      if (ap) nlvl = 0;
      else if (kind < 2) begin if (zh && m_mode[3]) nlvl = !m_lvl; end
      else if (kind == 2) begin
        if (st) nlvl = 1; else if (dn || !m_run) nlvl = 0;
      end else nlvl = m_run && (m_cnt < m_cmp);
      case (rd_addr)
        0: nrd = {8'd0, m_mode};
        1: nrd = {14'd0, m_flag, m_run};
        2: nrd = m_rel;
        3: nrd = m_cmp;
        4: nrd = m_cnt;
        default: nrd = 0;
      endcase
      if (wc) m_run = wr_data[0]; else if (dn) m_run = 0;
      if (zh) m_flag = 1; else if (wc && wr_data[1]) m_flag = 0;
      if (wr_en && wr_addr == 2) m_rel = wr_data;
      if (wr_en && wr_addr == 3) m_cmp = wr_data;
      if (cl && (m_pv || wm)) begin m_mode = wm ? wr_data[7:0] : m_pend; m_pv = 0; end
      else if (wm && !(m_run || cl)) begin m_mode = wr_data[7:0]; m_pv = 0; end
      else if (wm) begin m_pend = wr_data[7:0]; m_pv = 1; end
      m_cnt = ncnt; m_lvl = nlvl; m_rd = nrd;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = evt_in;
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (running && !rst) begin
      n_cmp = n_cmp + 3;
      if (rd_data !== m_rd) begin
        n_bad++; $display("FAIL %s rd_data act=%h exp=%h", cur_req, rd_data, m_rd);
      end
      if (tmr_out !== (m_lvl ^ m_mode[2])) begin
        n_bad++; $display("FAIL %s tmr_out act=%b exp=%b", cur_req, tmr_out, m_lvl ^ m_mode[2]);
      end
      if (uf_flag !== m_flag) begin
        n_bad++; $display("FAIL %s uf_flag act=%b exp=%b", cur_req, uf_flag, m_flag);
      end
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++; $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input string tag, input logic [15:0] exp);
    @(negedge clk); rd_addr = a;
    @(negedge clk); chk(tag, rd_data, exp);
    rd_addr = 3'd4;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_evt(input int hi, input int lo);
    @(negedge clk); evt_in = 1'b1; idle(hi);
    evt_in = 1'b0; idle(lo);
  endtask

  task automatic finish_run();
    running = 1'b0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    idle(3);
    rst = 1'b0;
    // R1 reset state
    cur_req = "R1";
    idle(1);
    chk("R1 count", rd_data, 16'h0000);
    chk("R1 out", {15'd0, tmr_out}, 16'd0);
    chk("R1 flag", {15'd0, uf_flag}, 16'd0);
    rd(3'd0, "R1 mode", 16'h0000);

    // R3 reload timer from the always-on source
    cur_req = "R3";
    wr(3'd2, 16'd5);
    wr(3'd0, 16'h0000);
    wr(3'd1, 16'h0001);
    idle(20);
    chk("R3 flag after underflow", {15'd0, uf_flag}, 16'd1);
    wr(3'd1, 16'h0002);
    idle(2);
    chk("R9 flag cleared", {15'd0, uf_flag}, 16'd0);

    // R2 / R11 disabled source holds the count; R7 pending mode write
    cur_req = "R11";
    wr(3'd2, 16'd7);
    wr(3'd0, 16'h00C0);
    wr(3'd1, 16'h0001);
    idle(10);
    rd(3'd4, "R11 count held on disabled source", 16'd7);
    cur_req = "R7";
    wr(3'd0, 16'h0040);
    rd(3'd0, "R7 mode still active value", 16'h00C0);
    wr(3'd1, 16'h0000);
    rd(3'd0, "R7 mode applied on stop", 16'h0040);
    cur_req = "R2";
    wr(3'd1, 16'h0001);
    idle(30);
    wr(3'd1, 16'h0002);
    idle(2);

    // R4 event counting
    cur_req = "R4";
    wr(3'd2, 16'd10);
    wr(3'd0, 16'h0001);
    wr(3'd1, 16'h0001);
    for (int i = 0; i < 4; i++) pulse_evt(3, 3);
    idle(5);
    rd(3'd4, "R4 four edges counted", 16'd6);
    @(negedge clk); evt_in = 1'b1;
    idle(12);
    rd(3'd4, "R4 held level counts once", 16'd5);
    evt_in = 1'b0;
    idle(4);
    wr(3'd1, 16'h0002);

    // R5 one-shot
    cur_req = "R5";
    wr(3'd2, 16'd4);
    wr(3'd0, 16'h0002);
    wr(3'd1, 16'h0001);
    chk("R5 output high after start", {15'd0, tmr_out}, 16'd1);
    idle(10);
    chk("R5 output low after run", {15'd0, tmr_out}, 16'd0);
    rd(3'd1, "R5 run cleared, flag set", 16'h0002);

    // R8 inversion and toggle
    cur_req = "R8";
    wr(3'd1, 16'h0002);
    wr(3'd0, 16'h0006);
    chk("R8 inverted idle output", {15'd0, tmr_out}, 16'd1);
    wr(3'd2, 16'd2);
    wr(3'd0, 16'h0008);
    wr(3'd1, 16'h0001);
    idle(25);
    wr(3'd1, 16'h0002);
    idle(2);

    // R6 PWM over a full wrap
    cur_req = "R6";
    wr(3'd3, 16'hFFF0);
    wr(3'd0, 16'h0003);
    wr(3'd1, 16'h0001);
    idle(10);
    chk("R6 output low above compare", {15'd0, tmr_out}, 16'd0);
    idle(20);
    chk("R6 output high below compare", {15'd0, tmr_out}, 16'd1);
    idle(65536);
    chk("R6 flag after wrap", {15'd0, uf_flag}, 16'd1);
    wr(3'd1, 16'h0002);
    idle(3);
    chk("R6 output low when stopped", {15'd0, tmr_out}, 16'd0);

    // R10 address map readback
    cur_req = "R10";
    rd(3'd3, "R10 compare readback", 16'hFFF0);
    rd(3'd2, "R10 reload readback", 16'd2);
    rd(3'd6, "R10 unmapped reads zero", 16'h0000);
    finish_run();
  end
endmodule